// File: doc/BRIEF.md
# Multi-mode built-in self-test register

This block is an N-bit register meant to sit where ordinary flip-flops would bound a combinational block. In system operation it loads the parallel word presented on `par_in` every clock. During self-test the same flip-flops are reused in three ways:

- as a pattern generator that drives the block under test;
- as a multiple-input signature compactor that folds that block's responses into a signature;
- as a serial scan chain, used to load a seed before generation and to unload the signature afterwards.

Two mode pins choose among load, clear, scan and the shared generator/compactor datapath. The shift direction runs from bit 0 toward bit N-1, with external XOR feedback into bit 0.

A third pin, `gen_sel`, is honoured when the `GEN_SEL_EN` parameter is set. When asserted, it blanks the parallel inputs inside the register, so the compactor runs as a pure generator. Without it, the same effect is obtained by driving `par_in` to all zeros. The generator seed must be non-zero: the all-zero state maps onto itself.

Top module: `bist_reg`

## Requirements
- R1: While `rst_n` is low, `par_out` is all zeros, and it stays zero until the first mode-selected update after release.
- R2: With `{mode_b1,mode_b2}` = 2'b11, `par_out` takes the value of `par_in` at the next rising clock edge.
- R3: With `{mode_b1,mode_b2}` = 2'b01, `par_out` becomes all zeros at the next rising clock edge, whatever the data and scan inputs are.
- R4: With `{mode_b1,mode_b2}` = 2'b00, the register shifts one place toward the top: bit 0 takes `scan_in` and bit i takes old bit i-1. In every mode, `scan_out` equals bit N-1 of `par_out`.
- R5: With `{mode_b1,mode_b2}` = 2'b10 and `gen_sel` low, the register compacts. The new bit 0 is the feedback XOR `par_in[0]`, and the new bit i is old bit i-1 XOR `par_in[i]`. For the default N=8, the feedback is the XOR of old bits 7, 5, 4 and 3, which corresponds to x^8+x^6+x^5+x^4+1.
- R6: With `{mode_b1,mode_b2}` = 2'b10 and `gen_sel` high, `par_in` has no effect. The register steps as in R5 with all data inputs taken as zero.
- R7: In mode 2'b10 with `gen_sel` low and `par_in` held at zero, the register follows exactly the same sequence as in R6.
- R8: In generator operation from any non-zero seed, the default 8-bit register visits all 255 non-zero states before returning to the seed.
- R9: In generator operation, an all-zero state remains all-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_b1 | input | 1 | Mode select, upper bit |
| mode_b2 | input | 1 | Mode select, lower bit |
| gen_sel | input | 1 | Generator (1) versus compactor (0) in mode 2'b10 |
| par_in | input | N | Parallel data / response word |
| scan_in | input | 1 | Serial input into bit 0 |
| par_out | output | N | Register contents |
| scan_out | output | 1 | Serial output, bit N-1 |

## Verification
The compactor is driven with a changing pseudo-random response word. This separates a correct per-bit XOR of the data inputs from a swapped or missing tap. The same stepping is then repeated with `gen_sel` high while noise sits on `par_in`, which shows that the inputs are truly blanked. A further run holds `par_in` at zero with `gen_sel` low, which shows that zero forcing alone turns the compactor into a generator. A full 255-step generator run from a scanned-in seed separates a maximal feedback polynomial from a short-cycling one. A cleared register stepped in generator mode exposes any feedback that could escape the all-zero state.

// File: rtl/bist_reg.sv
module bist_reg #(
  parameter int              N          = 8,
  parameter logic [N-1:0]    TAPS       = 8'hB8,
  parameter bit              GEN_SEL_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_b1,
  input  logic         mode_b2,
  input  logic         gen_sel,
  input  logic [N-1:0] par_in,
  input  logic         scan_in,
  output logic [N-1:0] par_out,
  output logic         scan_out
);

  logic [N-1:0] q;
  logic [N-1:0] din;
  logic         fb;

  assign fb  = ^(q & TAPS);
  assign din = (GEN_SEL_EN && gen_sel) ? '0 : par_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else begin
      unique case ({mode_b1, mode_b2})
        2'b11: q <= par_in;
        2'b01: q <= '0;
        2'b00: q <= {q[N-2:0], scan_in};
        2'b10: q <= {q[N-2:0], fb} ^ din;
        default: q <= q;
      endcase
    end
  end

  assign par_out  = q;
  assign scan_out = q[N-1];

endmodule

// File: rtl/bist_reg_chk.sv
module bist_reg_chk #(
  parameter int   N          = 8,
  parameter bit   GEN_SEL_EN = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_b1,
  input logic         mode_b2,
  input logic         gen_sel,
  input logic [N-1:0] par_in,
  input logic         scan_in,
  input logic [N-1:0] par_out,
  input logic         scan_out
);

  logic gen_on;
  assign gen_on = GEN_SEL_EN && gen_sel;

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b1 && mode_b2) |=> par_out == $past(par_in)); // R2

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_b1 && mode_b2) |=> par_out == '0); // R3

  AST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_b1 && !mode_b2) |=> (par_out[0] == $past(scan_in)) && (par_out[N-1:1] == $past(par_out[N-2:0]))); // R4

  AST_SCAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    scan_out == par_out[N-1]); // R4

  AST_COMPACT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b1 && !mode_b2 && !gen_on) |=> par_out[N-1:1] == ($past(par_out[N-2:0]) ^ $past(par_in[N-1:1]))); // R5

  AST_GEN_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b1 && !mode_b2 && gen_on) |=> par_out[N-1:1] == $past(par_out[N-2:0])); // R6

  AST_GEN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_b1 && !mode_b2 && gen_on && par_out == '0) |=> par_out == '0); // R9

endmodule

bind bist_reg bist_reg_chk #(.N(N), .GEN_SEL_EN(GEN_SEL_EN)) u_bist_reg_chk (
  .clk(clk), .rst_n(rst_n), .mode_b1(mode_b1), .mode_b2(mode_b2),
  .gen_sel(gen_sel), .par_in(par_in), .scan_in(scan_in),
  .par_out(par_out), .scan_out(scan_out)
);

// File: tb/test_bist_reg.sv
module test_bist_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b1 = 1'b1, b2 = 1'b1, gs = 1'b0, si = 1'b0;
  logic [7:0] z = 8'h00;
  logic [7:0] q;
  logic       so;
  logic [7:0] m = 8'h00;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  bist_reg i_bist_reg (
    .clk(clk), .rst_n(rst_n), .mode_b1(b1), .mode_b2(b2), .gen_sel(gs),
    .par_in(z), .scan_in(si), .par_out(q), .scan_out(so)
  );

  task automatic check(string req);
    n_chk++;
    if (q !== m || so !== m[7]) begin
      n_fail++;
      $display("FAIL %s: par_out=%h scan_out=%b expected %h/%b", req, q, so, m, m[7]);
    end
  endtask

  task automatic step(logic mb1, logic mb2, logic g, logic [7:0] d, logic s, string req);
    logic [7:0] eff;
    logic       fbk;
    b1 = mb1; b2 = mb2; gs = g; z = d; si = s;
    @(posedge clk);
    fbk = m[7] ^ m[5] ^ m[4] ^ m[3];
    eff = g ? 8'h00 : d;
    case ({mb1, mb2})
      2'b11: m = d;
      2'b01: m = 8'h00;
      2'b00: m = {m[6:0], s};
      default: m = {m[6:0], fbk} ^ eff;
    endcase
    @(negedge clk);
    check(req);
  endtask

  task automatic scan_seed(logic [7:0] seed);
    for (int k = 7; k >= 0; k--) step(1'b0, 1'b0, 1'b0, 8'hFF, seed[k], "R4");
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    done = 1'b1;
  end

  initial begin
    bit         seen [256];
    logic [7:0] seed;
    int         period;
    @(negedge clk); @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    // R2 load
    step(1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, "R2");
    // R3 clear
    step(1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, "R3");
    // R4 scan
    scan_seed(8'hD2);
    // R5 compaction with varying responses
    for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 1'b0, 8'($urandom), 1'b0, "R5");
    // R6 generator ignores noisy inputs
    for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 1'b1, 8'($urandom), 1'($urandom), "R6");
    // R7 zero forcing
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R7");
    // R8 maximal length
    seed = 8'h01;
    step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R2");
    scan_seed(seed);
    foreach (seen[k]) seen[k] = 1'b0;
    period = 0;
    for (int k = 1; k <= 255; k++) begin
      step(1'b1, 1'b0, 1'b1, 8'h5A, 1'b0, "R8");
      if (q != seed) begin
        n_chk++;
        if (seen[q] || q == 8'h00) begin
          n_fail++;
          $display("FAIL R8: state %h repeated at step %0d, expected fresh non-zero state", q, k);
        end
        seen[q] = 1'b1;
      end else if (period == 0) period = k;
    end
    n_chk++;
    if (period != 255) begin
      n_fail++;
      $display("FAIL R8: period=%0d expected 255", period);
    end
    // R9 lockup
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, "R3");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, "R9");
    // R1 reset mid-run
    step(1'b1, 1'b1, 1'b0, 8'h77, 1'b0, "R2");
    rst_n = 1'b0; m = 8'h00;
    #1;
    check("R1");
    @(negedge clk);
    check("R1");
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule